// File: doc/BRIEF.md
# NAND Flash Bus Cycle Bridge

This block turns accesses from a simple synchronous register bus into byte-wide NAND flash bus cycles. Accesses to the flash window get their cycle type from fixed address bits inside the window. A plain data cycle keeps both latch enables low. A command cycle raises the command latch enable (CLE). An address cycle raises the address latch enable (ALE). A write drives the low byte of the write data onto the flash data pins and pulses the write strobe low. A read pulses the read strobe low and returns the byte it sampled.

Each flash access has three parts: one setup cycle, a strobe phase whose length is a parameter, and one hold cycle. The requester is stalled for the whole access and gets a single-cycle ready pulse at the end. Register-space accesses reach a control word that holds an enable bit and an assert bit for each attached chip. From those two bits the block drives one registered, active-low chip select per chip.

Top module: `nand_strobe_bridge`

## Requirements
- R1: In the flash window, an address with bit 16 set is an address cycle (ALE high, CLE low). An address with bit 16 clear and bit 15 set is a command cycle (CLE high, ALE low). Any other address is a data cycle with both low. Bit 16 wins when both bits are set, and the lower address bits are ignored.
- R2: CLE and ALE are never high in the same cycle, and both are low whenever no flash access is in progress.
- R3: A flash write holds WE# low for exactly STROBE_CYCLES cycles while RE# stays high. The output enable is high and the data pins carry write-data bits [7:0] throughout the strobe.
- R4: A flash read holds RE# low for exactly STROBE_CYCLES cycles while WE# stays high and the output enable stays low. The byte present on the data inputs in the last low cycle is returned in read-data bits [7:0], and the upper bits are zero.
- R5: A flash access stalls the bus. Ready is a one-cycle pulse that comes STROBE_CYCLES+2 cycles after the request is accepted (one setup cycle, the strobe, one hold cycle). A register access returns ready in the cycle after it is accepted.
- R6: The control word sits at register offset 0x50. Bit 2x is the enable of chip x and bit 2x+1 is its assert. It resets to zero, and a read returns its 2*NCHIP bits with every higher bit zero.
- R7: CE#[x] is low only when both the enable bit and the assert bit of chip x are set. It takes its new value in the cycle after the control write is accepted.
- R8: A control write that leaves the bit pair of chip x unchanged leaves CE#[x] unchanged in every cycle.
- R9: A register read at any other offset returns zero. A register write at any other offset leaves the control word and all chip selects unchanged.
- R10: After reset CLE and ALE are low, WE# and RE# are high, every CE# is high, the output enable is low and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_win | input | 1 | 1 selects the flash window, 0 the register space |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Offset inside the selected space |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| nand_dq_in | input | 8 | Flash data pins, inbound |
| nand_dq_out | output | 8 | Flash data pins, outbound |
| nand_dq_oe | output | 1 | Output enable for the flash data pins |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_ce_n | output | NCHIP | Active-low chip selects |

## Verification
The bench aims at the window address with both type bits set. A decoder without the priority rule would raise CLE and ALE together there, or issue a command cycle in place of an address cycle. It measures every strobe's length and the stall until ready, so an off-by-one in the phase counter shows up as a strobe one cycle too short or too long, or as read data sampled from the wrong cycle. It rewrites the control word with some chips' bit pairs unchanged and watches those selects every cycle, which catches a select that pulses or one decoded from a single bit. It also writes to an unmapped register offset and reads the control word back, which catches a decoder that aliases other offsets onto it.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/nsb_decode.sv
module nsb_decode
  import nsb_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CMD_BIT  = 15,
  parameter int ALAT_BIT = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output cyc_kind_e         kind
);
  // Address bit has priority, so the two latch enables can never both be chosen.
  always_comb begin
    if (addr[ALAT_BIT])      kind = CYC_ADDR;
    else if (addr[CMD_BIT])  kind = CYC_CMD;
    else                     kind = CYC_DATA;
  end
endmodule

// File: rtl/nsb_ctrl_reg.sv
module nsb_ctrl_reg #(
  parameter int              NCHIP    = 4,
  parameter int              ADDR_W   = 17,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                hit,
  output logic [2*NCHIP-1:0]  ctrl_q,
  output logic [NCHIP-1:0]    ce_n
);
  localparam int CTRL_W = 2 * NCHIP;

  logic wr_hit;

  assign hit    = (addr == CTRL_OFF);
  assign wr_hit = acc && we && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_hit) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  // Each select is loaded from the incoming word at the same edge as the
  // control word, so an unchanged pair reloads the same value.
  for (genvar gi = 0; gi < NCHIP; gi++) begin : g_chip
    logic sel_n_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_n_q <= 1'b1;
      end else if (wr_hit) begin
        sel_n_q <= ~(wdata[2*gi] & wdata[2*gi+1]);
      end
    end
    assign ce_n[gi] = sel_n_q;
  end
endmodule

// File: rtl/nsb_strobe_seq.sv
module nsb_strobe_seq
  import nsb_pkg::*;
#(
  parameter int STROBE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_write,
  input  cyc_kind_e  kind,
  input  logic [7:0] wbyte,
  output logic       idle,
  output logic       last_strobe,
  output logic       done,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic       dq_oe,
  output logic [7:0] dq_out
);
  localparam int CNT_W = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  assign idle        = (phase == PH_IDLE);
  assign last_strobe = (phase == PH_STROBE) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      done   <= 1'b0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          done <= 1'b0;
          if (start) begin
            phase  <= PH_SETUP;
            cle    <= (kind == CYC_CMD);
            ale    <= (kind == CYC_ADDR);
            wr_q   <= is_write;
            dq_oe  <= is_write;
            dq_out <= is_write ? wbyte : 8'h00;
          end
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= '0;
          we_n  <= ~wr_q;
          re_n  <= wr_q;
        end
        PH_STROBE: begin
          if (cnt == CNT_LAST) begin
            phase <= PH_HOLD;
            we_n  <= 1'b1;
            re_n  <= 1'b1;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          done  <= 1'b0;
          cle   <= 1'b0;
          ale   <= 1'b0;
          dq_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_strobe_bridge.sv
module nand_strobe_bridge
  import nsb_pkg::*;
#(
  parameter int NCHIP         = 4,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 32,
  parameter int STROBE_CYCLES = 3,
  parameter int CMD_BIT       = 15,
  parameter int ALAT_BIT      = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_win,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [7:0]        nand_dq_in,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [NCHIP-1:0]  nand_ce_n
);
  localparam int CTRL_W = 2 * NCHIP;

  cyc_kind_e          kind;
  logic               seq_idle;
  logic               seq_last;
  logic               seq_done;
  logic               win_go;
  logic               reg_go;
  logic               reg_ack_q;
  logic               ctrl_hit;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  rdata_q;

  assign win_go = bus_req && bus_win && seq_idle && !seq_done;
  assign reg_go = bus_req && !bus_win && !reg_ack_q;

  nsb_decode #(
    .ADDR_W   (ADDR_W),
    .CMD_BIT  (CMD_BIT),
    .ALAT_BIT (ALAT_BIT)
  ) u_decode (
    .addr (bus_addr),
    .kind (kind)
  );

  nsb_ctrl_reg #(
    .NCHIP    (NCHIP),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_OFF (CTRL_OFF)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .acc    (reg_go),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .hit    (ctrl_hit),
    .ctrl_q (ctrl_q),
    .ce_n   (nand_ce_n)
  );

  nsb_strobe_seq #(
    .STROBE_CYCLES (STROBE_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (win_go),
    .is_write    (bus_we),
    .kind        (kind),
    .wbyte       (bus_wdata[7:0]),
    .idle        (seq_idle),
    .last_strobe (seq_last),
    .done        (seq_done),
    .cle         (nand_cle),
    .ale         (nand_ale),
    .we_n        (nand_we_n),
    .re_n        (nand_re_n),
    .dq_oe       (nand_dq_oe),
    .dq_out      (nand_dq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      reg_ack_q <= reg_go;
      if (reg_go) begin
        rdata_q <= (!bus_we && ctrl_hit) ? DATA_W'(ctrl_q) : '0;
      end else if (seq_last && nand_we_n) begin
        rdata_q <= DATA_W'(nand_dq_in);
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_ready = reg_ack_q | seq_done;
endmodule

// File: rtl/nsb_checker.sv
module nsb_checker #(
  parameter int NCHIP         = 4,
  parameter int STROBE_CYCLES = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cle,
  input logic               ale,
  input logic               we_n,
  input logic               re_n,
  input logic               dq_oe,
  input logic [7:0]         dq_out,
  input logic               ready,
  input logic [2*NCHIP-1:0] ctrl,
  input logic [NCHIP-1:0]   ce_n
);
  logic        strobe_lo;
  logic [15:0] lo_cnt;

  assign strobe_lo = !we_n || !re_n;

  always_ff @(posedge clk) begin
    if (rst)            lo_cnt <= '0;
    else if (strobe_lo) lo_cnt <= lo_cnt + 16'd1;
    else                lo_cnt <= '0;
  end

  assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  assert_write_drives_R3: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);

  assert_read_floats_R4: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);

  assert_latch_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe_lo && $past(strobe_lo)) |-> ($stable(cle) && $stable(ale) && $stable(dq_out)));

  assert_strobe_max_R3: assert property (@(posedge clk) disable iff (rst)
    strobe_lo |-> (lo_cnt < 16'(STROBE_CYCLES)));

  assert_strobe_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe_lo) && !strobe_lo) |-> (lo_cnt == 16'(STROBE_CYCLES)));

  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  for (genvar gi = 0; gi < NCHIP; gi++) begin : g_ce
    assert_ce_no_glitch_R8: assert property (@(posedge clk) disable iff (rst)
      $stable(ctrl[2*gi+1:2*gi]) |-> $stable(ce_n[gi]));

    assert_ce_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(ce_n[gi]) |-> (ctrl[2*gi+1:2*gi] == 2'b11));
  end
endmodule

bind nand_strobe_bridge nsb_checker #(
  .NCHIP         (NCHIP),
  .STROBE_CYCLES (STROBE_CYCLES)
) u_nsb_checker (
  .clk    (clk),
  .rst    (rst),
  .cle    (nand_cle),
  .ale    (nand_ale),
  .we_n   (nand_we_n),
  .re_n   (nand_re_n),
  .dq_oe  (nand_dq_oe),
  .dq_out (nand_dq_out),
  .ready  (bus_ready),
  .ctrl   (ctrl_q),
  .ce_n   (nand_ce_n)
);

// File: tb/tb_nand_strobe_bridge.sv
module tb_nand_strobe_bridge;
  localparam int NCHIP = 4;
  localparam int AW    = 17;
  localparam int DW    = 32;
  localparam int SC    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_req = 1'b0;
  logic          bus_win = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_ready;
  logic [7:0]    nand_dq_in = 8'h00;
  logic [7:0]    nand_dq_out;
  logic          nand_dq_oe;
  logic          nand_cle;
  logic          nand_ale;
  logic          nand_we_n;
  logic          nand_re_n;
  logic [NCHIP-1:0] nand_ce_n;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    bit       wr;
    bit       cle;
    bit       ale;
    bit [7:0] d;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  nand_strobe_bridge #(.NCHIP(NCHIP), .STROBE_CYCLES(SC)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .nand_dq_in(nand_dq_in), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Monitor: measures each strobe phase and compares with the scoreboard.
  int  mon_len = 0;
  exp_t mon_obs;
  bit   mon_drift;
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if (nand_cle && nand_ale) check(1'b0, "R2 cle/ale together", 2'b11, 2'b00);
      if (!nand_we_n || !nand_re_n) begin
        if (!nand_we_n && !nand_re_n) check(1'b0, "R3 both strobes low", 0, 1);
        if (mon_len == 0) begin
          mon_obs.wr  = !nand_we_n;
          mon_obs.cle = nand_cle;
          mon_obs.ale = nand_ale;
          mon_obs.d   = nand_dq_out;
          mon_drift   = (nand_dq_oe !== !nand_we_n);
        end else if (nand_cle != mon_obs.cle || nand_ale != mon_obs.ale ||
                     (mon_obs.wr && nand_dq_out != mon_obs.d) ||
                     nand_dq_oe !== mon_obs.wr) begin
          mon_drift = 1'b1;
        end
        mon_len++;
      end else if (mon_len > 0) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R3/R4 unexpected strobe", mon_len, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(mon_obs.wr == e.wr, "R3/R4 strobe kind", mon_obs.wr, e.wr);
          check(mon_len == SC, mon_obs.wr ? "R3 WE# low length" : "R4 RE# low length",
                mon_len, SC);
          check({mon_obs.cle, mon_obs.ale} == {e.cle, e.ale}, "R1 latch enables",
                {mon_obs.cle, mon_obs.ale}, {e.cle, e.ale});
          check(!mon_drift, "R3/R4 pins stable with oe during strobe", mon_drift, 0);
          if (e.wr) check(mon_obs.d == e.d, "R3 write byte", mon_obs.d, e.d);
        end
        mon_len = 0;
      end
      if (mon_len == 0 && nand_we_n && nand_re_n && !bus_req && !bus_ready &&
          (nand_cle || nand_ale))
        check(1'b0, "R2 latch enable high while idle", {nand_cle, nand_ale}, 0);
    end
  end

  task automatic access(input bit win, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    bus_win   = win;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = wd;
    bus_req   = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready && lat < 100);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic win_write(input logic [AW-1:0] a, input logic [7:0] b,
                           input bit ecle, input bit eale, input string tag);
    logic [DW-1:0] rd;
    int lat;
    exp_t e;
    e.wr = 1'b1; e.cle = ecle; e.ale = eale; e.d = b;
    sb_q.push_back(e);
    access(1'b1, 1'b1, a, {24'hABCDEF, b}, rd, lat);
    check(lat == SC + 2, {"R5 write stall ", tag}, lat, SC + 2);
  endtask

  task automatic win_read(input logic [AW-1:0] a, input logic [7:0] pin,
                          input bit ecle, input bit eale, input string tag);
    logic [DW-1:0] rd;
    int lat;
    exp_t e;
    e.wr = 1'b0; e.cle = ecle; e.ale = eale; e.d = 8'h00;
    sb_q.push_back(e);
    nand_dq_in = pin;
    access(1'b1, 1'b0, a, '0, rd, lat);
    check(lat == SC + 2, {"R5 read stall ", tag}, lat, SC + 2);
    check(rd == {24'h0, pin}, {"R4 read data ", tag}, rd, {24'h0, pin});
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [DW-1:0] rd;
    int lat;
    access(1'b0, 1'b1, a, wd, rd, lat);
    check(lat == 1, "R5 register write latency", lat, 1);
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [DW-1:0] rd);
    int lat;
    access(1'b0, 1'b0, a, '0, rd, lat);
    check(lat == 1, "R5 register read latency", lat, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [NCHIP-1:0] ce_before;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check({nand_cle, nand_ale} == 2'b00, "R10 latch enables", {nand_cle, nand_ale}, 0);
    check({nand_we_n, nand_re_n} == 2'b11, "R10 strobes", {nand_we_n, nand_re_n}, 3);
    check(nand_ce_n == 4'hF, "R10 chip selects", nand_ce_n, 4'hF);
    check(!nand_dq_oe && !bus_ready, "R10 oe and ready", {nand_dq_oe, bus_ready}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 and R3: writes of each cycle type
    win_write(17'h00000, 8'hA5, 0, 0, "data");
    win_write(17'h08000, 8'h70, 1, 0, "command");
    win_write(17'h10000, 8'h12, 0, 1, "address");
    win_write(17'h18000, 8'h34, 0, 1, "both type bits: address wins (R1)");
    win_write(17'h00123, 8'h5A, 0, 0, "low bits ignored (R1)");
    win_write(17'h08456, 8'hFF, 1, 0, "command with low bits (R1)");

    // R4: reads
    win_read(17'h00000, 8'h3C, 0, 0, "data");
    win_read(17'h08000, 8'hC3, 1, 0, "command offset");
    win_read(17'h10004, 8'h81, 0, 1, "address offset");

    // R6 reset value and read-back
    reg_rd(17'h50, rd);
    check(rd == 0, "R6 control reset value", rd, 0);
    reg_wr(17'h50, 32'hFFFF_0003);
    check(nand_ce_n == 4'b1110, "R7 chip0 selected", nand_ce_n, 4'b1110);
    reg_rd(17'h50, rd);
    check(rd == 32'h3, "R6 readback upper zero", rd, 32'h3);

    reg_wr(17'h50, 32'h0000_00C3);
    check(nand_ce_n == 4'b0110, "R7 chips 0 and 3", nand_ce_n, 4'b0110);

    // R8: change only chip1/2 bits; chips 0 and 3 must not move in any cycle
    ce_before = nand_ce_n;
    fork
      reg_wr(17'h50, 32'h0000_00CF);
      begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check(nand_ce_n[0] == ce_before[0] && nand_ce_n[3] == ce_before[3],
                "R8 unchanged selects steady", nand_ce_n, ce_before);
        end
      end
    join
    check(nand_ce_n == 4'b0100, "R7 chip1 both bits", nand_ce_n, 4'b0100);

    // R7: enable alone or assert alone does not select
    reg_wr(17'h50, 32'h0000_0009);
    check(nand_ce_n == 4'b1111, "R7 single bits do not select", nand_ce_n, 4'b1111);

    // R9: unmapped offsets
    reg_wr(17'h50, 32'h0000_0030);
    reg_wr(17'h54, 32'hFFFF_FFFF);
    check(nand_ce_n == 4'b1011, "R9 unmapped write keeps selects", nand_ce_n, 4'b1011);
    reg_rd(17'h50, rd);
    check(rd == 32'h30, "R9 unmapped write keeps control", rd, 32'h30);
    reg_rd(17'h54, rd);
    check(rd == 0, "R9 unmapped read is zero", rd, 0);

    // Window traffic while a chip is selected
    win_write(17'h08000, 8'h00, 1, 0, "command after reg access");
    win_read(17'h00000, 8'hE7, 0, 0, "data after reg access");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R3/R4 all strobes seen", sb_q.size(), 0);
    check({nand_cle, nand_ale} == 2'b00, "R2 idle latch enables low", {nand_cle, nand_ale}, 0);
    summary();
    $finish;
  end
endmodule